// File: doc/BRIEF.md
# Prescaled Watchdog Timeout Counter

The block is a watchdog timer. The system clock is divided by a fixed base ratio to give the watchdog base tick. A three-bit prescale select then divides that tick by a power of two. Each divided tick advances an eight-bit timeout counter. When the counter wraps from its top value back to zero, the block issues a one-cycle reset request and sets a sticky status flag. The system reset generator acts on the request.

Software keeps the system alive by writing an arming key and then a firing key. The firing key clears the base divider, the prescaler and the timeout counter. A disable input freezes all three at zero. A write of 1 to the status flag clears it.

With the default base ratio of 128 and a 5 MHz system clock, the base tick runs at 39.0625 kHz. The timeout then ranges from about 6.55 ms at the smallest divider to about 419 ms at the largest.

Top module: `prescaled_wdt`

## Requirements
- R1: The base tick fires once every BASE_DIV system clock cycles, counted from reset release, a key clear or the end of a disable period.
- R2: Prescale select codes 3'b000 and 3'b001 both divide the base tick by 1.
- R3: Prescale select codes 3'b010, 3'b011, 3'b100, 3'b101, 3'b110 and 3'b111 divide the base tick by 2, 4, 8, 16, 32 and 64 respectively.
- R4: The timeout counter is eight bits wide. With divider D, rst_req_o first goes high after exactly 256*D*BASE_DIV rising clock edges counted from the restart point. It goes high again every 256*D*BASE_DIV edges after that.
- R5: Each reset request lasts exactly one system clock cycle.
- R6: A key write of 8'h55 arms the sequence. A later key write of 8'hAA clears the base divider, the prescaler and the timeout counter, and disarms the sequence. Key writes of any other value between the two are ignored and leave the sequence armed.
- R7: A key write of 8'hAA while the sequence is not armed has no effect on the timeout.
- R8: While wd_off_i is high, the base divider, the prescaler and the counter hold at zero and no reset request is issued. Counting restarts from zero when wd_off_i falls.
- R9: wd_flag_o is set in the same cycle as the reset request and then stays set. A flag write with data 1 clears it, and a flag write with data 0 leaves it set. A request in the same cycle as a clearing write leaves the flag set.
- R10: When a key clear lands in the same cycle as a counter wrap, the clear wins: no request is issued, and counting restarts from zero.
- R11: After asynchronous reset, rst_req_o and wd_flag_o are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_sel_i | input | 3 | Prescale select code |
| key_wr_i | input | 1 | Key write strobe |
| key_data_i | input | KEY_W | Key write data |
| wd_off_i | input | 1 | Watchdog disable, active high |
| flag_wr_i | input | 1 | Status flag write strobe |
| flag_wr_data_i | input | 1 | Status flag write data (1 clears) |
| rst_req_o | output | 1 | One-cycle reset request |
| wd_flag_o | output | 1 | Sticky flag for a watchdog-caused reset |

## Verification
A key clear and a counter wrap can fall in the same cycle, and the clear must suppress the request. The bench computes from the timeout formula the edge at which the wrap would register. It arms the key early and places the firing write so that it is sampled on exactly that edge. The bench then checks that no request follows that edge, and that the next request arrives one full timeout period after the clear. A clearing flag write is also placed on a request edge, to check that setting the flag takes priority over clearing it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned SEL_W = 3;

  // Map a prescale select code to log2 of the divider.
  // Codes 000 and 001 both give 0 (divide by 1); 010..111 give 1..6.
  function automatic int unsigned div_log2(input logic [SEL_W-1:0] sel);
    if (sel[SEL_W-1:1] == '0) begin
      return 0;
    end
    return int'(sel) - 1;
  endfunction

  // Mask of the prescaler bits that must all be one for a divided tick.
  function automatic logic [15:0] div_mask(input logic [SEL_W-1:0] sel);
    logic [15:0] m;
    m = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < int'(div_log2(sel))) begin
        m[i] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/wdt_base_div.sv
module wdt_base_div #(
  parameter int unsigned DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = at_last & ~hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (hold_i || at_last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int unsigned PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             base_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  assign mask   = PRE_W'(div_mask(sel_i));
  assign tick_o = base_tick_i & ~hold_i & ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (hold_i) begin
      cnt_q <= '0;
    end else if (base_tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq #(
  parameter int unsigned     KEY_W    = 8,
  parameter logic [KEY_W-1:0] KEY_ARM  = 8'h55,
  parameter logic [KEY_W-1:0] KEY_FIRE = 8'hAA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] data_i,
  output logic             clear_o
);
  logic armed_q;

  assign clear_o = wr_i & armed_q & (data_i == KEY_FIRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (clear_o) begin
      armed_q <= 1'b0;
    end else if (wr_i && data_i == KEY_ARM) begin
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_tmo_counter.sv
module wdt_tmo_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign count_o = cnt_q;
  assign wrap_o  = tick_i & ~hold_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (hold_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/prescaled_wdt.sv
module prescaled_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned      BASE_DIV = 128,
  parameter int unsigned      PRE_W    = 6,
  parameter int unsigned      CNT_W    = 8,
  parameter int unsigned      KEY_W    = 8,
  parameter logic [KEY_W-1:0] KEY_ARM  = 8'h55,
  parameter logic [KEY_W-1:0] KEY_FIRE = 8'hAA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       presc_sel_i,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_data_i,
  input  logic             wd_off_i,
  input  logic             flag_wr_i,
  input  logic             flag_wr_data_i,
  output logic             rst_req_o,
  output logic             wd_flag_o
);
  // Named internal events for the checker.
  logic             key_clear;
  logic             hold;
  logic             base_tick;
  logic             div_tick;
  logic             wrap_evt;
  logic [CNT_W-1:0] tmo_count;
  logic             req_q;
  logic             flag_q;

  assign hold = wd_off_i | key_clear;

  wdt_key_seq #(
    .KEY_W   (KEY_W),
    .KEY_ARM (KEY_ARM),
    .KEY_FIRE(KEY_FIRE)
  ) u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (key_wr_i),
    .data_i (key_data_i),
    .clear_o(key_clear)
  );

  wdt_base_div #(.DIV(BASE_DIV)) u_base (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hold_i(hold),
    .tick_o(base_tick)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (hold),
    .base_tick_i(base_tick),
    .sel_i      (presc_sel_i),
    .tick_o     (div_tick)
  );

  wdt_tmo_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .tick_i (div_tick),
    .count_o(tmo_count),
    .wrap_o (wrap_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q <= wrap_evt;
      if (wrap_evt) begin
        flag_q <= 1'b1;
      end else if (flag_wr_i && flag_wr_data_i) begin
        flag_q <= 1'b0;
      end
    end
  end

  assign rst_req_o = req_q;
  assign wd_flag_o = flag_q;
endmodule

// File: rtl/prescaled_wdt_chk.sv
module prescaled_wdt_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_req_o,
  input logic             wd_flag_o,
  input logic             wd_off_i,
  input logic             flag_wr_i,
  input logic             flag_wr_data_i,
  input logic             key_clear,
  input logic             wrap_evt,
  input logic [CNT_W-1:0] tmo_count
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R5
  AST_WRAP_TO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_evt |=> rst_req_o); // R4
  AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_clear |=> (tmo_count == '0)); // R6
  AST_CLEAR_BEATS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_clear |=> !rst_req_o); // R10
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_off_i |=> (!rst_req_o && tmo_count == '0)); // R8
  AST_FLAG_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> wd_flag_o); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_flag_o && !(flag_wr_i && flag_wr_data_i)) |=> wd_flag_o); // R9
endmodule

bind prescaled_wdt prescaled_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rst_req_o     (rst_req_o),
  .wd_flag_o     (wd_flag_o),
  .wd_off_i      (wd_off_i),
  .flag_wr_i     (flag_wr_i),
  .flag_wr_data_i(flag_wr_data_i),
  .key_clear     (key_clear),
  .wrap_evt      (wrap_evt),
  .tmo_count     (tmo_count)
);

// File: tb/prescaled_wdt_test.sv
`timescale 1ns/1ps
module prescaled_wdt_test;
  localparam int B = 2;                 // base ratio used on the bench
  localparam int SEL_N = 8;
  localparam logic [2:0] SEL_TAB [SEL_N] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam int DIV_TAB [SEL_N] = '{1, 1, 2, 4, 8, 16, 32, 64};
  localparam int T1 = 256 * B;          // timeout with divider 1

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic key_wr = 1'b0;
  logic [7:0] key_data = 8'h00;
  logic wd_off = 1'b0;
  logic flag_wr = 1'b0;
  logic flag_data = 1'b0;
  logic rst_req;
  logic wd_flag;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  prescaled_wdt #(.BASE_DIV(B)) uut (
    .clk_i(clk), .rst_ni(rst_n), .presc_sel_i(sel), .key_wr_i(key_wr),
    .key_data_i(key_data), .wd_off_i(wd_off), .flag_wr_i(flag_wr),
    .flag_wr_data_i(flag_data), .rst_req_o(rst_req), .wd_flag_o(wd_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Reset, then release at a falling edge; later edges count from 1.
  task automatic do_reset(input logic [2:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    sel = s;
    key_wr = 1'b0;
    wd_off = 1'b0;
    flag_wr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic key_write(input logic [7:0] d);
    key_wr = 1'b1;
    key_data = d;
    @(negedge clk);
    key_wr = 1'b0;
  endtask

  task automatic flag_write(input logic d);
    flag_wr = 1'b1;
    flag_data = d;
    @(negedge clk);
    flag_wr = 1'b0;
  endtask

  // Count edges until rst_req is seen; -1 when the limit runs out.
  task automatic wait_req(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (rst_req) begin
        n = i;
        break;
      end
    end
  endtask

  initial begin
    int n;
    // R11: reset state
    @(negedge clk);
    check("R11 rst_req", int'(rst_req), 0);
    check("R11 wd_flag", int'(wd_flag), 0);

    // R1 R2 R3 R4: walk the select table
    for (int v = 0; v < SEL_N; v++) begin
      do_reset(SEL_TAB[v]);
      wait_req(256 * DIV_TAB[v] * B + 4, n);
      check((DIV_TAB[v] == 1) ? "R2 timeout" : "R3 timeout", n, 256 * DIV_TAB[v] * B);
    end

    // R4 periodic, R5 width, R9 flag behaviour
    do_reset(3'd1);
    wait_req(T1 + 4, n);
    check("R4 first", n, T1);
    check("R9 flag set", int'(wd_flag), 1);
    @(negedge clk);
    check("R5 width", int'(rst_req), 0);
    flag_write(1'b0);
    check("R9 write 0 ignored", int'(wd_flag), 1);
    wait_req(T1 + 4, n);
    check("R4 period", n, T1 - 2);
    flag_write(1'b1);
    check("R9 write 1 clears", int'(wd_flag), 0);

    // R9: request and clearing write on the same edge
    do_reset(3'd0);
    idle(T1 - 1);
    flag_wr = 1'b1;
    flag_data = 1'b1;
    @(negedge clk);
    flag_wr = 1'b0;
    check("R9 set wins req", int'(rst_req), 1);
    check("R9 set wins flag", int'(wd_flag), 1);

    // R6: arm, stray value, fire restarts the timeout
    do_reset(3'd0);
    idle(300);
    key_write(8'h55);
    key_write(8'h3C);
    key_write(8'hAA);
    wait_req(T1 + 4, n);
    check("R6 clear restarts", n, T1);

    // R7: fire key alone does nothing
    do_reset(3'd0);
    idle(300);
    key_write(8'hAA);
    wait_req(T1, n);
    check("R7 lone AA", n, T1 - 301);

    // R8: disable holds off requests, restart from zero
    do_reset(3'd0);
    idle(200);
    wd_off = 1'b1;
    wait_req(2 * T1, n);
    check("R8 no req while off", n, -1);
    wd_off = 1'b0;
    wait_req(T1 + 4, n);
    check("R8 restart", n, T1);

    // R10: clear sampled on the wrap edge
    do_reset(3'd0);
    idle(400);
    key_write(8'h55);
    idle(T1 - 1 - 401);
    key_write(8'hAA);
    check("R10 no req on wrap", int'(rst_req), 0);
    wait_req(T1 + 4, n);
    check("R10 restart", n, T1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule